// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Loader

This block is the write-only configuration port of a frequency synthesizer. An external controller drives three wires: a serial clock, a serial data line and a load-enable line. Each serial clock rising edge pushes one data bit into a 24-bit shift register, most significant bit first. When load-enable goes high, the word is committed. Its three lowest bits name one of eight configuration registers, and the remaining 21 upper bits become that register's new contents.

The three wires are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are detected in the system clock domain. A small state machine with three states controls the commit. In the reset state `ST_HOLD` the machine waits until load-enable is low, and the move `HOLD->SHIFT` happens once it is. In `ST_SHIFT` the serial bits are shifted in, and a high load-enable takes `SHIFT->COMMIT`. `ST_COMMIT` lasts exactly one system cycle and writes the addressed register. From there the machine takes `COMMIT->HOLD` while load-enable is still high, or `COMMIT->SHIFT` if it has already dropped. Serial clock edges are ignored in `ST_HOLD` and `ST_COMMIT`.

The outputs are the eight register contents, packed into one flat vector, and a one-cycle update strobe per register.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset every configuration register reads zero and every update strobe is low.
- R2: The word is shifted MSB first. At commit, bits [23:3] of the word are written to the register whose index equals bits [2:0]. Register i appears on `cfg_regs[i*21 +: 21]`.
- R3: A commit leaves every register other than the addressed one unchanged.
- R4: Each commit raises only the addressed register's strobe bit, `upd_strobe[i]`, for exactly one system clock cycle.
- R5: If more than 24 bits arrive before a commit, only the last 24 bits received are used.
- R6: If fewer than 24 bits arrive, the shift register still holds the last 24 bits received. The new bits fill the low end and older bits from earlier words fill the rest. The shift register is not cleared by a commit.
- R7: Serial clock edges that occur while load-enable is high do not shift. A later commit with no new bits rewrites the same word.
- R8: A load-enable held high for many cycles commits exactly once. A load-enable that is already high when reset is released does not commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load-enable; a rising edge commits the word |
| cfg_regs | output | 168 | Eight 21-bit configuration registers, register i at [i*21 +: 21] |
| upd_strobe | output | 8 | One-cycle write pulse per register |

## Verification
The hardest case to reach from the ports is a commit made from a shift register that holds a mix of two words. It occurs when a short burst of bits follows an earlier full word, and when clock edges arrive during a held load-enable. The bench keeps its own 24-bit model of the bits received. It sends deliberately short and long bursts, toggles the serial clock while load-enable is held, and re-commits without new bits. It then compares the register and strobe state with the model after each commit.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
    localparam int WORD_W_DEF = 24;
    localparam int ADDR_W_DEF = 3;

    typedef enum logic [1:0] {
        ST_SHIFT  = 2'd0,
        ST_COMMIT = 2'd1,
        ST_HOLD   = 2'd2
    } ld_state_e;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] q_out
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_in[b]};
        end
        assign q_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              data_s,
    input  logic              shift_ok,
    output logic [WORD_W-1:0] word
);
    logic sclk_prev;
    logic sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            word      <= '0;
        end else begin
            sclk_prev <= sclk_s;
            if (sclk_rise && shift_ok)
                word <= {word[WORD_W-2:0], data_s};
        end
    end
endmodule

// File: rtl/scfg_ctrl.sv
module scfg_ctrl
    import scfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le_s,
    output logic shift_ok,
    output logic commit
);
    ld_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SHIFT:  if (le_s)  state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = le_s ? ST_HOLD : ST_SHIFT;
            ST_HOLD:   if (!le_s) state_nx = ST_SHIFT;
            default:   state_nx = ST_HOLD;
        endcase
    end

    always_comb begin
        shift_ok = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_SHIFT:  shift_ok = ~le_s;
            ST_COMMIT: commit   = 1'b1;
            ST_HOLD:   ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/scfg_bank.sv
module scfg_bank #(
    parameter int ADDR_W    = 3,
    parameter int PAYLOAD_W = 21,
    localparam int NUM_REGS = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [PAYLOAD_W-1:0]          payload,
    output logic [NUM_REGS*PAYLOAD_W-1:0] regs_flat,
    output logic [NUM_REGS-1:0]           strobe
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit;
        logic [PAYLOAD_W-1:0] value;

        assign hit = commit && (addr == ADDR_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                value     <= '0;
                strobe[i] <= 1'b0;
            end else begin
                strobe[i] <= hit;
                if (hit) value <= payload;
            end
        end

        assign regs_flat[i*PAYLOAD_W +: PAYLOAD_W] = value;
    end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
    parameter int WORD_W = scfg_pkg::WORD_W_DEF,
    parameter int ADDR_W = scfg_pkg::ADDR_W_DEF,
    localparam int PAYLOAD_W = WORD_W - ADDR_W,
    localparam int NUM_REGS  = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ser_clk,
    input  logic                          ser_data,
    input  logic                          ser_le,
    output logic [NUM_REGS*PAYLOAD_W-1:0] cfg_regs,
    output logic [NUM_REGS-1:0]           upd_strobe
);
    logic              sclk_s, data_s, le_s;
    logic              shift_ok, commit;
    logic [WORD_W-1:0] word;

    scfg_sync #(.N(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ser_clk, ser_data, ser_le}),
        .q_out ({sclk_s, data_s, le_s})
    );

    scfg_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .data_s   (data_s),
        .shift_ok (shift_ok),
        .word     (word)
    );

    scfg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .le_s     (le_s),
        .shift_ok (shift_ok),
        .commit   (commit)
    );

    scfg_bank #(.ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .addr      (word[ADDR_W-1:0]),
        .payload   (word[WORD_W-1:ADDR_W]),
        .regs_flat (cfg_regs),
        .strobe    (upd_strobe)
    );
endmodule

// File: rtl/scfg_checker.sv
module scfg_checker #(
    parameter int NUM_REGS  = 8,
    parameter int PAYLOAD_W = 21
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_REGS*PAYLOAD_W-1:0] cfg_regs,
    input logic [NUM_REGS-1:0]           upd_strobe
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_regs == '0 && upd_strobe == '0));

    // R4
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_strobe));

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_strobe != '0) |=> (upd_strobe == '0));

    // R3
    regs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_strobe == '0) |-> $stable(cfg_regs));
endmodule

bind serial_cfg_port scfg_checker #(
    .NUM_REGS  (NUM_REGS),
    .PAYLOAD_W (PAYLOAD_W)
) u_scfg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_regs   (cfg_regs),
    .upd_strobe (upd_strobe)
);

// File: tb/test_serial_cfg_port.sv
`timescale 1ns/1ps
module test_serial_cfg_port;
    localparam int NR = 8;
    localparam int PW = 21;
    localparam int NV = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [NR*PW-1:0] cfg_regs;
    logic [NR-1:0]    upd_strobe;

    int n_checks = 0;
    int n_fail = 0;

    logic [23:0]   model_sr = '0;
    logic [PW-1:0] exp_regs [NR];

    // vector table: {payload, address}
    localparam logic [23:0] VEC [NV] = '{
        {21'h000001, 3'd0}, {21'h1FFFFF, 3'd7}, {21'h155555, 3'd3},
        {21'h0AAAAA, 3'd5}, {21'h123456, 3'd1}, {21'h0F0F0F, 3'd0}
    };

    always #2.5 clk = ~clk;

    serial_cfg_port i_serial_cfg_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .cfg_regs(cfg_regs), .upd_strobe(upd_strobe)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int k = n - 1; k >= 0; k--) begin
            ser_data = v[k];
            wait_neg(3);
            ser_clk = 1'b1;
            if (!ser_le) model_sr = {model_sr[22:0], v[k]};
            wait_neg(3);
            ser_clk = 1'b0;
            wait_neg(3);
        end
    endtask

    // raise load-enable, watch strobes, optionally toggle serial clock while high
    task automatic commit_word(input int hold, input int junk_edges,
                               output int pulses, output logic [NR-1:0] seen);
        pulses = 0;
        seen = '0;
        wait_neg(3);
        ser_le = 1'b1;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            if (upd_strobe != '0) begin
                pulses++;
                seen = upd_strobe;
            end
        end
        for (int j = 0; j < junk_edges; j++) begin
            ser_data = 1'b1;
            wait_neg(3);
            ser_clk = 1'b1;
            wait_neg(3);
            ser_clk = 1'b0;
            wait_neg(3);
            if (upd_strobe != '0) pulses++;
        end
        ser_le = 1'b0;
        wait_neg(6);
        if (upd_strobe != '0) pulses++;
    endtask

    task automatic verify(input string tag, input int pulses, input logic [NR-1:0] seen);
        int a;
        a = int'(model_sr[2:0]);
        exp_regs[a] = model_sr[23:3];
        check(cfg_regs[a*PW +: PW] == exp_regs[a], {tag, " R2 addressed value"},
              64'(cfg_regs[a*PW +: PW]), 64'(exp_regs[a]));
        for (int i = 0; i < NR; i++) begin
            if (i != a)
                check(cfg_regs[i*PW +: PW] == exp_regs[i], {tag, " R3 other register"},
                      64'(cfg_regs[i*PW +: PW]), 64'(exp_regs[i]));
        end
        check(pulses == 1, {tag, " R4 strobe length"}, 64'(pulses), 64'd1);
        check(seen == NR'(1 << a), {tag, " R4 strobe bit"}, 64'(seen), 64'(1 << a));
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int p;
        logic [NR-1:0] s;
        for (int i = 0; i < NR; i++) exp_regs[i] = '0;
        ser_le = 1'b1;               // R8: high at reset release must not commit
        wait_neg(4);
        rst_n = 1'b1;
        wait_neg(8);
        check(cfg_regs == '0, "R1 registers zero", 64'(cfg_regs[63:0]), 64'd0);
        check(upd_strobe == '0, "R1 strobes low", 64'(upd_strobe), 64'd0);
        ser_le = 1'b0;
        wait_neg(6);
        check(cfg_regs == '0, "R8 no commit at reset release", 64'(cfg_regs[63:0]), 64'd0);

        for (int v = 0; v < NV; v++) begin
            send_bits(64'(VEC[v]), 24);
            commit_word(12, 0, p, s);
            verify("table", p, s);
        end

        // R5: 30 bits, last 24 count
        send_bits(64'h2A_ABCDE2, 30);
        commit_word(12, 0, p, s);
        verify("R5 long burst", p, s);

        // R6: short burst of 8 bits mixes with older bits
        send_bits(64'hB6, 8);
        commit_word(12, 0, p, s);
        verify("R6 short burst", p, s);

        // R7: edges during high load-enable are ignored, re-commit same word
        send_bits(64'(({21'h0C0FFE, 3'd6})), 24);
        commit_word(6, 5, p, s);
        verify("R7 first commit", p, s);
        commit_word(12, 0, p, s);
        verify("R7 recommit", p, s);
        check(cfg_regs[6*PW +: PW] == 21'h0C0FFE, "R7 value kept",
              64'(cfg_regs[6*PW +: PW]), 64'h0C0FFE);

        // R8: long hold commits once
        send_bits(64'(({21'h054321, 3'd2})), 24);
        commit_word(60, 0, p, s);
        verify("R8 long hold", p, s);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule